// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Drive Sequencer

This block produces the drive levels for a passive, multiplexed liquid-crystal panel with up to four common lines and forty segment lines. A slow reference clock of roughly 32 kHz runs a two-stage timebase, made of a selectable prescaler followed by a 1-to-8 divider. The timebase cuts each frame into one time slot per common line. In each slot one common line is active. Every segment line is then driven to a level chosen by the pixel bit for that common, taken from a 160-bit display image.

The levels are 2-bit codes for ground, one third, two thirds and full supply. An external resistor or buffer network turns these codes into voltages. An on pixel has the full supply across it during its slot. Every other pixel has one third of the supply across it. The drive polarity alternates, so that no pixel is held at a net DC voltage. In the default waveform the polarity flips every frame. A low-power waveform flips it every second frame, which halves the number of level transitions. A one-cycle strobe marks the first cycle of each frame.

A segment-count field sets how many segment lines are driven. Segment lines 24 and above that lie beyond the count are handed back as plain outputs. For those lines the block forwards a caller-supplied data bit and raises an output-enable bit. Segment lines 0 to 23 are always driven.

Top module: `lcd_drive_seq`

## Requirements
- R1: While `enable` is low, every common and segment level is 0 and `frame_start` is 0. The counters are held cleared, so the first cycle with `enable` high is the first cycle of phase 0 with polarity 0.
- R2: Each phase lasts P*(div_sel+1) clock cycles. P is PRESC_LO when `presc_sel`=0 and PRESC_HI when it is 1.
- R3: The number of active commons is N = duty_sel+1. Phases run 0,1,...,N-1 and then repeat, and one frame is N phases. A common with an index of N or more is held at level 0.
- R4: During phase k, common k is at level 3 when the polarity is 0 and at level 0 when it is 1. The other commons below N are at level 1 (polarity 0) or level 2 (polarity 1).
- R5: During phase k, driven segment s uses pixel bit disp_mem[k*40+s]. When the bit is set, the segment is at level 0 (polarity 0) or 3 (polarity 1). When the bit is clear, it is at level 2 (polarity 0) or 1 (polarity 1). An on pixel therefore sees 3 steps against its active common, and every other pixel sees 1 step.
- R6: With `lp_wave`=0, the polarity is 0 in frame 0 and flips at the start of every later frame.
- R7: With `lp_wave`=1, the polarity is 0 in frames 0 and 1, 1 in frames 2 and 3, and continues flipping every second frame.
- R8: `frame_start` is high for exactly the first cycle of every frame, including the first enabled cycle.
- R9: The effective driven count is `seg_count` clamped to the range 24..40. A segment s of 24 or more that is not below the effective count is released. For a released segment, its level is 0, gpio_oe[s-24] is 1 and gpio_out[s-24] equals gpio_in[s-24]. For a driven segment, both of those bits are 0. Bits 15:8 map to segments 32..39 and bits 7:0 map to segments 24..31. The release does not depend on `enable`.
- R10: Segments 0..23 are never released, even when `seg_count` is below 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (~32 kHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global drive enable |
| presc_sel | input | 1 | Prescaler select: 0 = PRESC_LO, 1 = PRESC_HI |
| div_sel | input | 3 | Divider setting, divides by div_sel+1 |
| duty_sel | input | 2 | Number of commons minus one |
| lp_wave | input | 1 | Low-power waveform (polarity flips every second frame) |
| seg_count | input | 6 | Number of driven segment lines |
| disp_mem | input | 160 | Pixel image, bit c*40+s for common c and segment s |
| gpio_in | input | 16 | Data for released segment lines 24..39 |
| com_lvl | output | 8 | Level code of common c at bits 2c+1:2c |
| seg_lvl | output | 80 | Level code of segment s at bits 2s+1:2s |
| frame_start | output | 1 | High for the first cycle of each frame |
| gpio_oe | output | 16 | Output enable of released segment lines 24..39 |
| gpio_out | output | 16 | Data of released segment lines 24..39 |

## Verification
The bench builds the block with PRESC_LO=2 and PRESC_HI=4, and keeps the geometry at 4 commons and 40 segments. With those values a phase is at most 32 cycles and four frames take at most 512 cycles. This makes it affordable to sweep every duty setting, both waveforms, both prescalers and several divider values, and to compare every common, every segment and the frame strobe on every cycle of four whole frames. A separate sweep covers all 64 segment-count codes, with the block both enabled and disabled, to check the release boundary and the lines that can never be released.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_GND   = 2'd0;
    localparam lvl_t LVL_THIRD = 2'd1;
    localparam lvl_t LVL_TWO3  = 2'd2;
    localparam lvl_t LVL_VDD   = 2'd3;
endpackage

// File: rtl/lcd_drv_timebase.sv
module lcd_drv_timebase #(
    parameter int PRESC_LO = 16,
    parameter int PRESC_HI = 32,
    parameter int DIV_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             presc_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             phase_tick,
    output logic             at_zero
);
    localparam int PMAX  = (PRESC_HI > PRESC_LO) ? PRESC_HI : PRESC_LO;
    localparam int PRE_W = $clog2(PMAX + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [PRE_W-1:0] pre_last;
    logic pre_end, div_end;

    always_comb begin
        pre_last = presc_sel ? PRE_W'(PRESC_HI - 1) : PRE_W'(PRESC_LO - 1);
        pre_end  = (st_q.pre >= pre_last);
        div_end  = (st_q.div >= div_sel);
        st_d     = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (pre_end) begin
            st_d.pre = '0;
            st_d.div = div_end ? '0 : st_q.div + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        phase_tick = enable && pre_end && div_end;
        at_zero    = (st_q.pre == '0) && (st_q.div == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_drv_phase.sv
module lcd_drv_phase #(
    parameter int NUM_COM = 4,
    parameter int COM_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             phase_tick,
    input  logic [COM_W-1:0] duty_sel,
    input  logic             lp_wave,
    output logic [COM_W-1:0] phase,
    output logic             pol
);
    typedef struct packed {
        logic [COM_W-1:0] phase;
        logic             pol;
        logic             half;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic last_phase;

    always_comb begin
        last_phase = (st_q.phase >= duty_sel) ||
                     (st_q.phase >= COM_W'(NUM_COM - 1));
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (phase_tick) begin
            if (last_phase) begin
                st_d.phase = '0;
                if (lp_wave) begin
                    st_d.half = ~st_q.half;
                    if (st_q.half) st_d.pol = ~st_q.pol;
                end else begin
                    st_d.half = 1'b0;
                    st_d.pol  = ~st_q.pol;
                end
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
        phase = st_q.phase;
        pol   = st_q.pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_drv_pinmux.sv
module lcd_drv_pinmux #(
    parameter int NUM_SEG    = 40,
    parameter int GPIO_FIRST = 24,
    parameter int SCNT_W     = 6
) (
    input  logic [SCNT_W-1:0]             seg_count,
    input  logic [NUM_SEG-GPIO_FIRST-1:0] gpio_in,
    output logic [NUM_SEG-1:0]            released,
    output logic [NUM_SEG-GPIO_FIRST-1:0] gpio_oe,
    output logic [NUM_SEG-GPIO_FIRST-1:0] gpio_out
);
    genvar s;
    generate
        for (s = 0; s < NUM_SEG; s++) begin : g_pin
            if (s < GPIO_FIRST) begin : g_fixed
                assign released[s] = 1'b0;
            end else begin : g_free
                assign released[s] = (seg_count <= SCNT_W'(s));
                assign gpio_oe[s-GPIO_FIRST]  = released[s];
                assign gpio_out[s-GPIO_FIRST] = released[s] & gpio_in[s-GPIO_FIRST];
            end
        end
    endgenerate
endmodule

// File: rtl/lcd_drv_levels.sv
module lcd_drv_levels
    import lcd_drv_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 40,
    parameter int COM_W   = 2
) (
    input  logic                       enable,
    input  logic [COM_W-1:0]           phase,
    input  logic                       pol,
    input  logic [COM_W-1:0]           duty_sel,
    input  logic [NUM_COM*NUM_SEG-1:0] disp_mem,
    input  logic [NUM_SEG-1:0]         released,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);
    logic [NUM_SEG-1:0] row;

    always_comb begin
        row = '0;
        for (int c = 0; c < NUM_COM; c++) begin
            if (phase == COM_W'(c)) row = disp_mem[c*NUM_SEG +: NUM_SEG];
        end
    end

    genvar c, s;
    generate
        for (c = 0; c < NUM_COM; c++) begin : g_com
            lvl_t lv;
            always_comb begin
                if (!enable || (COM_W'(c) > duty_sel))
                    lv = LVL_GND;
                else if (phase == COM_W'(c))
                    lv = pol ? LVL_GND : LVL_VDD;
                else
                    lv = pol ? LVL_TWO3 : LVL_THIRD;
            end
            assign com_lvl[2*c +: 2] = lv;
        end
        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            lvl_t lv;
            always_comb begin
                if (!enable || released[s])
                    lv = LVL_GND;
                else if (row[s])
                    lv = pol ? LVL_VDD : LVL_GND;
                else
                    lv = pol ? LVL_THIRD : LVL_TWO3;
            end
            assign seg_lvl[2*s +: 2] = lv;
        end
    endgenerate
endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq #(
    parameter int NUM_COM    = 4,
    parameter int NUM_SEG    = 40,
    parameter int GPIO_FIRST = 24,
    parameter int PRESC_LO   = 16,
    parameter int PRESC_HI   = 32,
    parameter int DIV_W      = 3,
    localparam int COM_W     = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
    localparam int SCNT_W    = $clog2(NUM_SEG + 1),
    localparam int GPIO_N    = NUM_SEG - GPIO_FIRST
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       presc_sel,
    input  logic [DIV_W-1:0]           div_sel,
    input  logic [COM_W-1:0]           duty_sel,
    input  logic                       lp_wave,
    input  logic [SCNT_W-1:0]          seg_count,
    input  logic [NUM_COM*NUM_SEG-1:0] disp_mem,
    input  logic [GPIO_N-1:0]          gpio_in,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl,
    output logic                       frame_start,
    output logic [GPIO_N-1:0]          gpio_oe,
    output logic [GPIO_N-1:0]          gpio_out
);
    logic             phase_tick, at_zero, pol;
    logic [COM_W-1:0] phase;
    logic [NUM_SEG-1:0] released;

    lcd_drv_timebase #(
        .PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI), .DIV_W(DIV_W)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
        .div_sel(div_sel), .phase_tick(phase_tick), .at_zero(at_zero)
    );

    lcd_drv_phase #(.NUM_COM(NUM_COM), .COM_W(COM_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase_tick(phase_tick),
        .duty_sel(duty_sel), .lp_wave(lp_wave), .phase(phase), .pol(pol)
    );

    lcd_drv_pinmux #(
        .NUM_SEG(NUM_SEG), .GPIO_FIRST(GPIO_FIRST), .SCNT_W(SCNT_W)
    ) u_mux (
        .seg_count(seg_count), .gpio_in(gpio_in), .released(released),
        .gpio_oe(gpio_oe), .gpio_out(gpio_out)
    );

    lcd_drv_levels #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .COM_W(COM_W)) u_lv (
        .enable(enable), .phase(phase), .pol(pol), .duty_sel(duty_sel),
        .disp_mem(disp_mem), .released(released),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    assign frame_start = enable && at_zero && (phase == '0);
endmodule

// File: rtl/lcd_drive_seq_chk.sv
module lcd_drive_seq_chk #(
    parameter int NUM_COM    = 4,
    parameter int NUM_SEG    = 40,
    parameter int GPIO_FIRST = 24,
    parameter int COM_W      = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                enable,
    input logic [COM_W-1:0]                    duty_sel,
    input logic [2*NUM_COM-1:0]                com_lvl,
    input logic [2*NUM_SEG-1:0]                seg_lvl,
    input logic                                frame_start,
    input logic [NUM_SEG-GPIO_FIRST-1:0]       gpio_oe
);
    localparam int GN = NUM_SEG - GPIO_FIRST;

    logic [NUM_COM-1:0] vdd_com, hi_com;
    logic [NUM_SEG-1:0] vdd_seg;
    logic [GN-1:0]      live_hi;

    always_comb begin
        for (int c = 0; c < NUM_COM; c++) begin
            vdd_com[c] = (com_lvl[2*c +: 2] == 2'd3);
            hi_com[c]  = (c > 0) && (com_lvl[2*c +: 2] != 2'd0);
        end
        for (int s = 0; s < NUM_SEG; s++) vdd_seg[s] = (seg_lvl[2*s +: 2] == 2'd3);
        for (int j = 0; j < GN; j++) live_hi[j] = (seg_lvl[2*(GPIO_FIRST+j) +: 2] != 2'd0);
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (com_lvl == '0) && (seg_lvl == '0) && !frame_start);

    p_unused_com_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == '0) |-> (hi_com == '0));

    p_one_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ($countones(vdd_com) <= 1));

    p_seg_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (vdd_com != '0)) |-> (vdd_seg == '0));

    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    p_released_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_oe & live_hi) == '0);

    p_release_from_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_oe & ~{1'b1, gpio_oe[GN-1:1]}) == '0);
endmodule

bind lcd_drive_seq lcd_drive_seq_chk #(
    .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .GPIO_FIRST(GPIO_FIRST), .COM_W(COM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .duty_sel(duty_sel),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_start(frame_start),
    .gpio_oe(gpio_oe)
);

// File: tb/lcd_drive_seq_test.sv
module lcd_drive_seq_test;
    localparam int NC = 4, NS = 40, GF = 24, PLO = 2, PHI = 4;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, presc_sel = 1'b0, lp_wave = 1'b0;
    logic [2:0]  div_sel = '0;
    logic [1:0]  duty_sel = '0;
    logic [5:0]  seg_count = 6'd40;
    logic [NC*NS-1:0] disp_mem = '0;
    logic [15:0] gpio_in = '0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;
    logic frame_start;
    logic [15:0] gpio_oe, gpio_out;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    lcd_drive_seq #(.PRESC_LO(PLO), .PRESC_HI(PHI)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
        .div_sel(div_sel), .duty_sel(duty_sel), .lp_wave(lp_wave),
        .seg_count(seg_count), .disp_mem(disp_mem), .gpio_in(gpio_in),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_start(frame_start),
        .gpio_oe(gpio_oe), .gpio_out(gpio_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_com(int c, int ncom, int ph, int pol);
        if (c >= ncom) return 0;
        if (c == ph) return pol ? 0 : 3;
        return pol ? 2 : 1;
    endfunction

    function automatic int exp_seg(bit on, int pol);
        if (on) return pol ? 3 : 0;
        return pol ? 1 : 2;
    endfunction

    task automatic run_cfg(input int ps, input int dv, input int dt, input int lp, input int pat);
        int len, ncom, flen, ph, fr, pol, tot;
        @(negedge clk);
        enable = 1'b0; presc_sel = ps[0]; div_sel = dv[2:0]; duty_sel = dt[1:0];
        lp_wave = lp[0]; seg_count = 6'd40;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                disp_mem[c*NS+s] = (((c*7 + s*3 + pat) % 3) == 0);
        @(negedge clk); #1;
        check("R1 idle com", int'(com_lvl), 0);
        check("R1 idle seg", int'(|seg_lvl), 0);
        check("R1 idle strobe", int'(frame_start), 0);
        @(negedge clk);
        enable = 1'b1;
        len  = (ps ? PHI : PLO) * (dv + 1);
        ncom = dt + 1;
        flen = len * ncom;
        tot  = 4 * flen;
        for (int t = 0; t < tot; t++) begin
            if (t > 0) @(negedge clk);
            #1;
            ph  = (t / len) % ncom;
            fr  = t / flen;
            pol = lp ? ((fr / 2) % 2) : (fr % 2);
            check("R8 frame strobe", int'(frame_start), int'((t % flen) == 0));
            check(lp ? "R7 polarity" : "R6 polarity", int'(com_lvl[2*ph +: 2]), pol ? 0 : 3);
            for (int c = 0; c < NC; c++)
                if (c != ph)
                    check(c >= ncom ? "R3 unused common" : "R4 common level",
                          int'(com_lvl[2*c +: 2]), exp_com(c, ncom, ph, pol));
            for (int s = 0; s < NS; s++)
                check(s == 0 ? "R2 phase row seg0" : "R5 segment level",
                      int'(seg_lvl[2*s +: 2]), exp_seg(disp_mem[ph*NS+s], pol));
        end
    endtask

    task automatic gpio_sweep(input bit en);
        int eff;
        @(negedge clk);
        enable = 1'b0; disp_mem = '0; gpio_in = 16'hA5C3;
        @(negedge clk);
        enable = en;
        for (int k = 0; k < 64; k++) begin
            seg_count = k[5:0];
            gpio_in = ~gpio_in;
            #1;
            eff = (k < GF) ? GF : ((k > NS) ? NS : k);
            for (int s = 0; s < NS; s++) begin
                if (s >= GF) begin
                    check("R9 oe", int'(gpio_oe[s-GF]), int'(s >= eff));
                    check("R9 out", int'(gpio_out[s-GF]), (s >= eff) ? int'(gpio_in[s-GF]) : 0);
                    check("R9 level", int'(seg_lvl[2*s +: 2]), (en && s < eff) ? 2 : 0);
                end else begin
                    check("R10 fixed seg", int'(seg_lvl[2*s +: 2]), en ? 2 : 0);
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #45 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 reset com", int'(com_lvl), 0);
        check("R1 reset strobe", int'(frame_start), 0);
        for (int dt = 0; dt < 4; dt++)
            for (int lp = 0; lp < 2; lp++)
                for (int ps = 0; ps < 2; ps++)
                    for (int di = 0; di < 3; di++)
                        run_cfg(ps, (di == 0) ? 0 : ((di == 1) ? 2 : 7), dt, lp, dt + di);
        gpio_sweep(1'b1);
        gpio_sweep(1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule